// File: doc/BRIEF.md
# Two-Set Ping-Pong Banked Frame Store

This block stores frame data in two identical memory sets used in ping-pong fashion. Each set holds three equal banks. At any time one set is active and serves a compute engine through three buses: one write bus and two independent read buses. Each of the three buses is attached to a different bank of the active set. The attachment is a programmable permutation, so any bank can play any role.

The set that is not active is reached through a separate load port. That port can write any of its three banks and read them back. A producer can therefore fill the next frame while the compute side works on the current one. A single swap strobe exchanges the roles of the two sets and installs a new bank permutation in the same edge. Loaded data then appears on the compute buses without being copied.

Each bank holds 2^AW words of DW bits. Every read has exactly one cycle of latency. The active set and the permutation change only on a swap strobe. Any access issued in the swap cycle still uses the configuration that was in force before the swap.

Top module: `fb_dual_set`

## Requirements
- R1: After reset, set 0 is active and permutation code 0 is in force. Under code 0 the write bus drives bank 0, read bus A reads bank 1 and read bus B reads bank 2.
- R2: Permutation codes are given as (write bank, A bank, B bank): 0=(0,1,2), 1=(0,2,1), 2=(1,0,2), 3=(1,2,0), 4=(2,0,1), 5=(2,1,0).
- R3: A write-bus write with wr_en_i high stores wr_data_i at wr_addr_i in the active-set bank mapped to the write bus. No other bank in either set changes, except through the load port.
- R4: The word that ra_addr_i (or rb_addr_i) selects in the active-set bank mapped to bus A (or B) appears on ra_data_o (or rb_data_o) one cycle after the address is presented.
- R5: The active set and the permutation change only on a clock edge where swap_i is high. A write or read presented in that same cycle uses the previous set and permutation.
- R6: On a swap with map_req_i equal to 6 or 7, the permutation keeps its previous value. The active set is still taken from set_req_i.
- R7: The load port targets bank ld_bank_i (0, 1 or 2) of the inactive set. ld_we_i writes ld_wdata_i at ld_addr_i. ld_rdata_o shows the word at ld_addr_i one cycle later. With ld_bank_i equal to 3, nothing is written and ld_rdata_o reads 0.
- R8: Data written into the inactive set through the load port is kept across a swap and is then readable on the read buses of the newly active set.
- R9: When the load port writes and reads the same word in one cycle, ld_rdata_o returns the content before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_i | input | 1 | Strobe that installs set_req_i and map_req_i |
| set_req_i | input | 1 | Set to make active on the next swap |
| map_req_i | input | 3 | Permutation code to install on the next swap |
| wr_en_i | input | 1 | Write-bus enable |
| wr_addr_i | input | AW | Write-bus word address |
| wr_data_i | input | DW | Write-bus data |
| ra_addr_i | input | AW | Read bus A address |
| ra_data_o | output | DW | Read bus A data, one cycle later |
| rb_addr_i | input | AW | Read bus B address |
| rb_data_o | output | DW | Read bus B data, one cycle later |
| ld_we_i | input | 1 | Load-port write enable |
| ld_bank_i | input | 2 | Bank of the inactive set used by the load port |
| ld_addr_i | input | AW | Load-port word address |
| ld_wdata_i | input | DW | Load-port write data |
| ld_rdata_o | output | DW | Load-port read data, one cycle later |

## Verification
The bench attacks the swap cycle. It issues writes and reads together with the strobe. A design that applied the new permutation early would return the wrong bank's word, or would write into the freshly activated set. Every legal code is installed and then written and read through. Codes 6 and 7 are sent at a swap: a design that decoded them, or that also held the set, would show words from the wrong bank or the wrong set. Load-port bank 3, and a write and read of the same word in one cycle, catch a stray write and a write-first read respectively. Random traffic then checks that the two sets never leak into each other.

// File: rtl/fb_pkg.sv
package fb_pkg;

  localparam int NUM_SETS  = 2;
  localparam int NUM_BANKS = 3;
  localparam int BANK_W    = 2;
  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 6;

  typedef logic [BANK_W-1:0] bank_idx_t;
  typedef logic [CODE_W-1:0] map_code_t;

  // role assignment of the active set: which bank each bus uses
  typedef struct packed {
    bank_idx_t wr;
    bank_idx_t ra;
    bank_idx_t rb;
  } route_t;

  function automatic logic code_legal(input map_code_t c);
    return int'(c) < NUM_CODES;
  endfunction

  function automatic route_t code_to_route(input map_code_t c);
    route_t r;
    case (c)
      3'd0:    r = '{wr: 2'd0, ra: 2'd1, rb: 2'd2};
      3'd1:    r = '{wr: 2'd0, ra: 2'd2, rb: 2'd1};
      3'd2:    r = '{wr: 2'd1, ra: 2'd0, rb: 2'd2};
      3'd3:    r = '{wr: 2'd1, ra: 2'd2, rb: 2'd0};
      3'd4:    r = '{wr: 2'd2, ra: 2'd0, rb: 2'd1};
      3'd5:    r = '{wr: 2'd2, ra: 2'd1, rb: 2'd0};
      default: r = '{wr: 2'd0, ra: 2'd1, rb: 2'd2};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fb_bank.sv
module fb_bank #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, read-before-write, registered read
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/fb_ctrl.sv
module fb_ctrl
  import fb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      swap_i,
  input  logic      set_req_i,
  input  map_code_t map_req_i,
  output logic      act_set_o,
  output route_t    route_o
);
  logic      act_set_q;
  map_code_t code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_set_q <= 1'b0;
      code_q    <= '0;
    end else if (swap_i) begin
      act_set_q <= set_req_i;
      if (code_legal(map_req_i)) code_q <= map_req_i;
    end
  end

  assign act_set_o = act_set_q;
  assign route_o   = code_to_route(code_q);

  // R5: configuration is frozen between strobes
  assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    !swap_i |=> ($stable(act_set_o) && $stable(route_o)));

  // R5: the set follows the request on a strobe
  assert_set_follows_R5: assert property (@(posedge clk) disable iff (rst)
    swap_i |=> (act_set_o == $past(set_req_i)));

  // R6: illegal codes leave the permutation as it was
  assert_bad_code_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (swap_i && !code_legal(map_req_i)) |=> $stable(route_o));

  // R2: a legal code is installed on the strobe
  assert_code_taken_R2: assert property (@(posedge clk) disable iff (rst)
    (swap_i && code_legal(map_req_i)) |=> (route_o == code_to_route($past(map_req_i))));

endmodule

// File: rtl/fb_steer.sv
module fb_steer
  import fb_pkg::*;
#(
  parameter int AW      = 6,
  parameter int DW      = 16,
  parameter int BANK_ID = 0
) (
  input  logic          active_i,
  input  route_t        route_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] ra_addr_i,
  input  logic [AW-1:0] rb_addr_i,
  input  logic          ld_we_i,
  input  bank_idx_t     ld_bank_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_wdata_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic [AW-1:0] raddr_o
);
  localparam bank_idx_t MY_ID = bank_idx_t'(BANK_ID);

  always_comb begin
    if (active_i) begin
      we_o    = wr_en_i && (route_i.wr == MY_ID);
      waddr_o = wr_addr_i;
      wdata_o = wr_data_i;
      if (route_i.ra == MY_ID)      raddr_o = ra_addr_i;
      else if (route_i.rb == MY_ID) raddr_o = rb_addr_i;
      else                          raddr_o = wr_addr_i;
    end else begin
      we_o    = ld_we_i && (ld_bank_i == MY_ID);
      waddr_o = ld_addr_i;
      wdata_o = ld_wdata_i;
      raddr_o = ld_addr_i;
    end
  end

endmodule

// File: rtl/fb_rsel.sv
module fb_rsel
  import fb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   act_set_i,
  input  bank_idx_t                              ra_bank_i,
  input  bank_idx_t                              rb_bank_i,
  input  bank_idx_t                              ld_bank_i,
  input  logic [NUM_SETS-1:0][NUM_BANKS-1:0][DW-1:0] dout_i,
  output logic [DW-1:0]                          ra_data_o,
  output logic [DW-1:0]                          rb_data_o,
  output logic [DW-1:0]                          ld_data_o
);
  // selections captured with the address so a swap cannot redirect
  // a read already in flight
  logic      set_q;
  bank_idx_t ra_q, rb_q, ld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      set_q <= 1'b0;
      ra_q  <= 2'd1;
      rb_q  <= 2'd2;
      ld_q  <= 2'd3;
    end else begin
      set_q <= act_set_i;
      ra_q  <= ra_bank_i;
      rb_q  <= rb_bank_i;
      ld_q  <= ld_bank_i;
    end
  end

  function automatic logic [DW-1:0] pick(
    input logic [NUM_BANKS-1:0][DW-1:0] row,
    input bank_idx_t                    b
  );
    case (b)
      2'd0:    return row[0];
      2'd1:    return row[1];
      2'd2:    return row[2];
      default: return '0;
    endcase
  endfunction

  always_comb begin
    ra_data_o = pick(dout_i[set_q],  ra_q);
    rb_data_o = pick(dout_i[set_q],  rb_q);
    ld_data_o = pick(dout_i[~set_q], ld_q);
  end

endmodule

// File: rtl/fb_dual_set.sv
module fb_dual_set
  import fb_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swap_i,
  input  logic          set_req_i,
  input  logic [2:0]    map_req_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o,
  input  logic          ld_we_i,
  input  logic [1:0]    ld_bank_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_wdata_i,
  output logic [DW-1:0] ld_rdata_o
);
  logic   act_set;
  route_t route;

  logic [NUM_SETS-1:0][NUM_BANKS-1:0]         bank_we;
  logic [NUM_SETS-1:0][NUM_BANKS-1:0][DW-1:0] bank_dout;

  fb_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .swap_i    (swap_i),
    .set_req_i (set_req_i),
    .map_req_i (map_req_i),
    .act_set_o (act_set),
    .route_o   (route)
  );

  for (genvar gs = 0; gs < NUM_SETS; gs++) begin : g_set
    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      logic [AW-1:0] waddr, raddr;
      logic [DW-1:0] wdata;

      fb_steer #(.AW(AW), .DW(DW), .BANK_ID(gb)) u_steer (
        .active_i   (act_set == gs[0]),
        .route_i    (route),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .ra_addr_i  (ra_addr_i),
        .rb_addr_i  (rb_addr_i),
        .ld_we_i    (ld_we_i),
        .ld_bank_i  (ld_bank_i),
        .ld_addr_i  (ld_addr_i),
        .ld_wdata_i (ld_wdata_i),
        .we_o       (bank_we[gs][gb]),
        .waddr_o    (waddr),
        .wdata_o    (wdata),
        .raddr_o    (raddr)
      );

      fb_bank #(.AW(AW), .DW(DW)) u_bank (
        .clk     (clk),
        .we_i    (bank_we[gs][gb]),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (bank_dout[gs][gb])
      );
    end

    // R3: at most one bank per set is written in a cycle
    assert_one_write_per_set_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(bank_we[gs]));
  end

  fb_rsel #(.DW(DW)) u_rsel (
    .clk       (clk),
    .rst       (rst),
    .act_set_i (act_set),
    .ra_bank_i (route.ra),
    .rb_bank_i (route.rb),
    .ld_bank_i (ld_bank_i),
    .dout_i    (bank_dout),
    .ra_data_o (ra_data_o),
    .rb_data_o (rb_data_o),
    .ld_data_o (ld_rdata_o)
  );

  // R3: the write bus never reaches the inactive set
  assert_inactive_only_load_R3: assert property (@(posedge clk) disable iff (rst)
    (bank_we[~act_set] != '0) |-> ld_we_i);

  // R7: the load port never reaches the active set
  assert_active_only_bus_R7: assert property (@(posedge clk) disable iff (rst)
    (bank_we[act_set] != '0) |-> wr_en_i);

endmodule

// File: tb/sim_fb_dual_set.sv
module sim_fb_dual_set;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic swap_i = 0, set_req_i = 0, wr_en_i = 0, ld_we_i = 0;
  logic [2:0] map_req_i = 0;
  logic [1:0] ld_bank_i = 0;
  logic [AW-1:0] wr_addr_i = 0, ra_addr_i = 0, rb_addr_i = 0, ld_addr_i = 0;
  logic [DW-1:0] wr_data_i = 0, ld_wdata_i = 0;
  logic [DW-1:0] ra_data_o, rb_data_o, ld_rdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_dual_set #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .swap_i(swap_i), .set_req_i(set_req_i),
    .map_req_i(map_req_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .ra_addr_i(ra_addr_i), .ra_data_o(ra_data_o),
    .rb_addr_i(rb_addr_i), .rb_data_o(rb_data_o), .ld_we_i(ld_we_i),
    .ld_bank_i(ld_bank_i), .ld_addr_i(ld_addr_i), .ld_wdata_i(ld_wdata_i),
    .ld_rdata_o(ld_rdata_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit chk_on = 0;
  bit done = 0;

  logic [DW-1:0] mdl [0:1][0:2][0:DEPTH-1];
  int cur_set = 0;
  int cur_code = 0;

  // role: 0 = write bus, 1 = read A, 2 = read B (R2 table)
  function automatic int bank_for(input int code, input int role);
    int t [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
    return t[code][role];
  endfunction

  task automatic compare(input string tag, input string what,
                         input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step(input bit swp, input bit sreq, input int mreq,
                      input bit we, input int waddr, input logic [DW-1:0] wdata,
                      input int ra, input int rb,
                      input bit lwe, input int lbank, input int laddr,
                      input logic [DW-1:0] ldata, input string tag);
    logic [DW-1:0] e_ra, e_rb, e_ld;
    swap_i = swp; set_req_i = sreq; map_req_i = 3'(mreq);
    wr_en_i = we; wr_addr_i = AW'(waddr); wr_data_i = wdata;
    ra_addr_i = AW'(ra); rb_addr_i = AW'(rb);
    ld_we_i = lwe; ld_bank_i = 2'(lbank); ld_addr_i = AW'(laddr); ld_wdata_i = ldata;
    // reads see the content before this edge's writes (R9, R5)
    e_ra = mdl[cur_set][bank_for(cur_code, 1)][ra];
    e_rb = mdl[cur_set][bank_for(cur_code, 2)][rb];
    e_ld = (lbank < 3) ? mdl[1-cur_set][lbank][laddr] : '0;
    if (we) mdl[cur_set][bank_for(cur_code, 0)][waddr] = wdata;
    if (lwe && lbank < 3) mdl[1-cur_set][lbank][laddr] = ldata;
    if (swp) begin
      cur_set = int'(sreq);
      if (mreq < 6) cur_code = mreq;
    end
    @(posedge clk);
    @(negedge clk);
    swap_i = 0; wr_en_i = 0; ld_we_i = 0;
    if (chk_on) begin
      compare(tag, "read A", ra_data_o, e_ra);
      compare(tag, "read B", rb_data_o, e_rb);
      compare(tag, "load read", ld_rdata_o, e_ld);
    end
  endtask

  task automatic rd(input int ra, input int rb, input int lbank, input int laddr,
                    input string tag);
    step(0, 0, 0, 0, 0, '0, ra, rb, 0, lbank, laddr, '0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // fill both sets through the load port
    for (int s = 0; s < 2; s++) begin
      for (int b = 0; b < 3; b++)
        for (int a = 0; a < DEPTH; a++)
          step(0, 0, 0, 0, 0, '0, 0, 0, 1, b, a,
               16'(((cur_set == 0 ? 1 : 0) * 3 + b + 1) << 12 | a), "init");
      step(1, (cur_set == 0), 0, 0, 0, '0, 0, 0, 0, 3, 0, '0, "init");
    end

    // reset again: memory contents are kept, configuration returns to default
    rst = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 0;
    cur_set = 0; cur_code = 0;
    chk_on = 1;

    // R1: default set 0 and code 0
    rd(7, 9, 0, 3, "R1");
    rd(0, 63, 2, 63, "R1");

    // R3: write bus lands in the mapped bank only
    step(0, 0, 0, 1, 5, 16'hBEEF, 5, 5, 0, 3, 0, '0, "R3");
    // R5: swap with write in same cycle uses the old mapping
    step(1, 0, 2, 1, 6, 16'hCAFE, 5, 5, 0, 0, 5, '0, "R5");
    rd(5, 5, 0, 5, "R3");
    rd(6, 6, 1, 6, "R5");

    // R2: every legal permutation
    for (int c = 0; c < 6; c++) begin
      step(1, 0, c, 1, c + 10, 16'(16'h0A00 + c), c + 1, c + 2, 0, 3, 0, '0, "R2");
      rd(c + 10, c + 10, 0, c + 10, "R2");
      step(0, 0, 0, 1, c + 11, 16'(16'h0B00 + c), c + 11, c + 11, 0, 3, 0, '0, "R2");
      rd(c + 11, c + 11, 1, 0, "R2");
    end

    // R6: codes 6 and 7 keep the permutation, set still changes
    step(1, 0, 3, 0, 0, '0, 1, 2, 0, 3, 0, '0, "R6");
    step(1, 1, 6, 0, 0, '0, 3, 4, 0, 0, 3, '0, "R6");
    rd(3, 4, 0, 3, "R6");
    step(1, 0, 7, 1, 12, 16'h6767, 12, 12, 0, 3, 0, '0, "R6");
    rd(12, 12, 2, 12, "R6");

    // R7: load port writes, reads, bank 3 is inert
    step(0, 0, 0, 0, 0, '0, 0, 0, 1, 2, 20, 16'h1234, "R7");
    rd(0, 0, 2, 20, "R7");
    step(0, 0, 0, 0, 0, '0, 0, 0, 1, 3, 20, 16'h5555, "R7");
    rd(20, 20, 0, 20, "R7");
    rd(20, 20, 1, 20, "R7");
    rd(20, 20, 2, 20, "R7");

    // R9: same-word write and read returns the old word
    step(0, 0, 0, 0, 0, '0, 0, 0, 1, 1, 30, 16'h7777, "R9");
    step(0, 0, 0, 0, 0, '0, 0, 0, 1, 1, 30, 16'h8888, "R9");
    rd(0, 0, 1, 30, "R9");

    // R8: loaded data becomes visible after a swap
    for (int b = 0; b < 3; b++)
      step(0, 0, 0, 0, 0, '0, 0, 0, 1, b, 40, 16'(16'hD000 + b), "R8");
    step(1, (cur_set == 0), 0, 0, 0, '0, 40, 40, 0, 0, 40, '0, "R8");
    rd(40, 40, 0, 40, "R8");
    step(1, cur_set == 1 ? 1 : 0, 5, 0, 0, '0, 40, 40, 0, 0, 40, '0, "R8");
    rd(40, 40, 1, 41, "R8");

    // random traffic: R4 read paths and R7 load port
    for (int i = 0; i < 3000; i++) begin
      bit sw = ($urandom % 8) == 0;
      step(sw, 1'($urandom), int'($urandom % 8),
           1'($urandom), int'($urandom % DEPTH), 16'($urandom),
           int'($urandom % DEPTH), int'($urandom % DEPTH),
           1'($urandom), int'($urandom % 4), int'($urandom % DEPTH), 16'($urandom),
           "R4 R7");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule